// File: doc/BRIEF.md
# Character Display Host Register Interface

This block is the front end that a host processor talks to when it drives a character display controller. Each transfer is one clock-wide strobe with two qualifiers: a register-select line and a read/write line. Together they choose one of four operations: writing an instruction, reading status, writing a data byte or reading a data byte. The block keeps an address counter, a direction bit, a prefetched data register and a busy flag. It also holds the two memories the host can reach: an 80-byte character memory and a 64-byte glyph memory.

Only the instructions that move the address counter or set its stepping direction are decoded here. Any other instruction code is accepted and raises the busy flag, and has no further effect. Host reads come from the data register. That register is refilled when an address is loaded and again after every completed data read, so a read returns its value in the same cycle. A narrow-bus option carries each byte as two transfers on the upper four data lines.

Top module: `lcd_host_regif`

## Requirements
- R1: Each strobe is decoded from {select, read}: 00 writes an instruction, 01 reads status, 10 writes data to the selected memory, 11 reads data from it. A status read changes no state.
- R2: A status read returns the busy flag on bit 7 and the 7-bit address counter on bits 6..0.
- R3: While busy is 1, instruction writes and data writes are ignored. The address counter, the direction, the memory selection and the memory contents stay unchanged.
- R4: The instruction 1aaaaaaa loads aaaaaaa into the address counter and selects character memory. The instruction 01aaaaaa loads aaaaaa and selects glyph memory.
- R5: The instruction 000001d0-style code (bits 7..2 = 000001) sets the direction from bit 1: 1 counts up, 0 counts down.
- R6: After each completed data write or data read, the address counter moves by one in the current direction.
- R7: Loading an address fetches the byte at that address into the data register. A completed data read fetches the byte at the new address.
- R8: Glyph memory holds 64 bytes at addresses 00h–3Fh and wraps between 3Fh and 00h in both directions. Character memory holds 80 bytes.
- R9: With two_line = 1, character addresses run 00h–27h and 40h–67h. Counting up goes 27h→40h and 67h→00h. Counting down goes 00h→67h and 40h→27h. Writes to addresses outside these ranges are dropped, and reads from them return 00h.
- R10: With two_line = 0, character addresses run 00h–4Fh and wrap between 4Fh and 00h.
- R11: With nibble_mode = 1, a byte moves as two transfers, high nibble first, on bus lines 7..4. bus_in[3:0] is ignored. Reads put the nibble on bus_out[7:4] with bus_out[3:0] = 0. The first half of a write does not raise busy.
- R12: Every accepted instruction or data write holds busy at 1 for exactly BUSY_CYCLES clock cycles. Reads never raise it.
- R13: After reset the address counter is 0, character memory is selected, the direction is up, busy is 0, both memories read 00h and the next nibble is the high one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| xfer_en | input | 1 | One-cycle transfer strobe |
| sel_data | input | 1 | 0 selects instruction/status, 1 selects data |
| rd_nwr | input | 1 | 1 reads, 0 writes |
| nibble_mode | input | 1 | 1 selects the two-transfer 4-bit bus |
| two_line | input | 1 | 1 selects the split two-line character address map |
| bus_in | input | 8 | Write data from host |
| bus_out | output | 8 | Read data to host, valid while rd_nwr is 1 |
| busy | output | 1 | Internal operation in progress |

## Verification
On every cycle the assertions check four things. Writes that arrive while busy leave the address counter alone. A status read moves nothing. Glyph addressing never sets bit 6. The first-line end of the character map steps to the second-line start. They also check that busy rises after each accepted write and that the 8-bit mode never leaves a half-transfer pending. Only the bench's scenarios can show the values that come back to the host: that the prefetch holds the right byte after an address load and after each read, that the wrap points and the memory contents are correct in both directions and both line maps, the nibble ordering, and that busy stays high for exactly the configured length.

// File: rtl/lcd_regif_pkg.sv
package lcd_regif_pkg;

    typedef enum logic [1:0] {
        OP_INSTR_WR  = 2'b00,
        OP_STATUS_RD = 2'b01,
        OP_DATA_WR   = 2'b10,
        OP_DATA_RD   = 2'b11
    } host_op_e;

    typedef struct packed {
        logic [6:0] ac;      // address counter
        logic       cg_sel;  // 1: glyph memory targeted
        logic       inc;     // 1: count up
        logic [7:0] dr;      // prefetched read byte
        logic       half;    // 1: low nibble is next
        logic [3:0] hold;    // captured high nibble
    } regif_state_t;

    localparam regif_state_t REGIF_RST = '{
        ac: 7'd0, cg_sel: 1'b0, inc: 1'b1, dr: 8'd0, half: 1'b0, hold: 4'd0
    };

endpackage

// File: rtl/lcd_dd_map.sv
module lcd_dd_map #(
    parameter int         DD_DEPTH   = 80,
    parameter logic [6:0] LINE2_BASE = 7'h40
) (
    input  logic [6:0]                  addr,
    input  logic                        two_line,
    output logic [$clog2(DD_DEPTH)-1:0] idx,
    output logic                        valid
);
    localparam int         AW       = $clog2(DD_DEPTH);
    localparam logic [6:0] LINE_LEN = 7'(DD_DEPTH / 2);
    localparam logic [6:0] LAST_ONE = 7'(DD_DEPTH - 1);

    logic [6:0] idx_full;

    always_comb begin
        idx_full = addr;
        valid    = 1'b0;
        if (two_line) begin
            if (addr < LINE_LEN) begin
                valid = 1'b1;
            end else if (addr >= LINE2_BASE && addr < LINE2_BASE + LINE_LEN) begin
                idx_full = addr - LINE2_BASE + LINE_LEN;
                valid    = 1'b1;
            end
        end else begin
            valid = (addr <= LAST_ONE);
        end
    end

    assign idx = idx_full[AW-1:0];

endmodule

// File: rtl/lcd_ac_stepper.sv
module lcd_ac_stepper #(
    parameter int         DD_DEPTH   = 80,
    parameter int         CG_DEPTH   = 64,
    parameter logic [6:0] LINE2_BASE = 7'h40
) (
    input  logic [6:0] ac,
    input  logic       cg_sel,
    input  logic       inc,
    input  logic       two_line,
    output logic [6:0] ac_next
);
    localparam logic [6:0] LINE_LEN  = 7'(DD_DEPTH / 2);
    localparam logic [6:0] END_LINE1 = LINE_LEN - 7'd1;
    localparam logic [6:0] END_LINE2 = LINE2_BASE + LINE_LEN - 7'd1;
    localparam logic [6:0] END_ONE   = 7'(DD_DEPTH - 1);
    localparam logic [6:0] END_CG    = 7'(CG_DEPTH - 1);

    always_comb begin
        ac_next = inc ? ac + 7'd1 : ac - 7'd1;
        if (cg_sel) begin
            if (inc && ac == END_CG)         ac_next = 7'd0;
            else if (!inc && ac == 7'd0)     ac_next = END_CG;
        end else if (two_line) begin
            if (inc) begin
                if (ac == END_LINE1)         ac_next = LINE2_BASE;
                else if (ac == END_LINE2)    ac_next = 7'd0;
            end else begin
                if (ac == 7'd0)              ac_next = END_LINE2;
                else if (ac == LINE2_BASE)   ac_next = END_LINE1;
            end
        end else begin
            if (inc && ac == END_ONE)        ac_next = 7'd0;
            else if (!inc && ac == 7'd0)     ac_next = END_ONE;
        end
    end

endmodule

// File: rtl/lcd_byte_ram.sv
module lcd_byte_ram #(
    parameter int DEPTH = 64
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     we,
    input  logic [$clog2(DEPTH)-1:0] waddr,
    input  logic [7:0]               wdata,
    input  logic [$clog2(DEPTH)-1:0] raddr,
    output logic [7:0]               rdata
);
    localparam int AW = $clog2(DEPTH);

    logic [7:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= 8'h00;
        end else if (we && int'(waddr) < DEPTH) begin
            mem_q[waddr] <= wdata;
        end
    end

    assign rdata = (int'(raddr) < DEPTH) ? mem_q[raddr] : 8'h00;

    logic unused_aw;
    assign unused_aw = (AW == 0);

endmodule

// File: rtl/lcd_busy_timer.sv
module lcd_busy_timer #(
    parameter int CYCLES = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy
);
    localparam int CW = $clog2(CYCLES + 1);
    localparam logic [CW-1:0] LOAD = CW'(CYCLES);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (start)               cnt_d = LOAD;
        else if (cnt_q != '0)    cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign busy = (cnt_q != '0);

    assert_busy_after_write_R12: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> busy);

endmodule

// File: rtl/lcd_host_regif.sv
module lcd_host_regif
    import lcd_regif_pkg::*;
#(
    parameter int         DD_DEPTH    = 80,
    parameter int         CG_DEPTH    = 64,
    parameter int         BUSY_CYCLES = 4,
    parameter logic [6:0] LINE2_BASE  = 7'h40
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       xfer_en,
    input  logic       sel_data,
    input  logic       rd_nwr,
    input  logic       nibble_mode,
    input  logic       two_line,
    input  logic [7:0] bus_in,
    output logic [7:0] bus_out,
    output logic       busy
);
    localparam int         DD_AW    = $clog2(DD_DEPTH);
    localparam int         CG_AW    = $clog2(CG_DEPTH);
    localparam logic [6:0] LINE_LEN = 7'(DD_DEPTH / 2);

    regif_state_t st_d, st_q;
    host_op_e     op;
    logic [7:0]   byte_in;
    logic         byte_done, instr_done, dwr_done, drd_done;
    logic         set_dd, set_cg, set_entry;
    logic [6:0]   step_next, fetch_ac;
    logic         fetch_cg;
    logic [DD_AW-1:0] dd_ridx, dd_widx;
    logic         dd_rvalid, dd_wvalid;
    logic [7:0]   dd_rdata, cg_rdata, fetch_byte;
    logic         dd_we, cg_we;
    logic [7:0]   view_byte;
    logic [6:0]   ac_q;

    assign op    = host_op_e'({sel_data, rd_nwr});
    assign ac_q  = st_q.ac;

    // Front end: byte assembly and completion
    always_comb begin
        byte_in   = nibble_mode ? {st_q.hold, bus_in[7:4]} : bus_in;
        byte_done = 1'b0;
        if (xfer_en) begin
            if (op == OP_INSTR_WR || op == OP_DATA_WR)
                byte_done = !busy && (!nibble_mode || st_q.half);
            else
                byte_done = !nibble_mode || st_q.half;
        end
    end

    assign instr_done = byte_done && (op == OP_INSTR_WR);
    assign dwr_done   = byte_done && (op == OP_DATA_WR);
    assign drd_done   = byte_done && (op == OP_DATA_RD);
    assign set_dd     = instr_done && byte_in[7];
    assign set_cg     = instr_done && (byte_in[7:6] == 2'b01);
    assign set_entry  = instr_done && (byte_in[7:2] == 6'b000001);

    lcd_ac_stepper #(
        .DD_DEPTH(DD_DEPTH), .CG_DEPTH(CG_DEPTH), .LINE2_BASE(LINE2_BASE)
    ) i_step (
        .ac(st_q.ac), .cg_sel(st_q.cg_sel), .inc(st_q.inc),
        .two_line(two_line), .ac_next(step_next)
    );

    // Prefetch target
    always_comb begin
        fetch_ac = st_q.ac;
        fetch_cg = st_q.cg_sel;
        if (set_dd) begin
            fetch_ac = byte_in[6:0];
            fetch_cg = 1'b0;
        end else if (set_cg) begin
            fetch_ac = {1'b0, byte_in[5:0]};
            fetch_cg = 1'b1;
        end else if (drd_done) begin
            fetch_ac = step_next;
        end
    end

    lcd_dd_map #(.DD_DEPTH(DD_DEPTH), .LINE2_BASE(LINE2_BASE)) i_map_rd (
        .addr(fetch_ac), .two_line(two_line), .idx(dd_ridx), .valid(dd_rvalid)
    );
    lcd_dd_map #(.DD_DEPTH(DD_DEPTH), .LINE2_BASE(LINE2_BASE)) i_map_wr (
        .addr(st_q.ac), .two_line(two_line), .idx(dd_widx), .valid(dd_wvalid)
    );

    assign dd_we = dwr_done && !st_q.cg_sel && dd_wvalid;
    assign cg_we = dwr_done && st_q.cg_sel;

    lcd_byte_ram #(.DEPTH(DD_DEPTH)) i_dd_ram (
        .clk(clk), .rst_n(rst_n), .we(dd_we), .waddr(dd_widx), .wdata(byte_in),
        .raddr(dd_ridx), .rdata(dd_rdata)
    );
    lcd_byte_ram #(.DEPTH(CG_DEPTH)) i_cg_ram (
        .clk(clk), .rst_n(rst_n), .we(cg_we), .waddr(st_q.ac[CG_AW-1:0]), .wdata(byte_in),
        .raddr(fetch_ac[CG_AW-1:0]), .rdata(cg_rdata)
    );

    assign fetch_byte = fetch_cg ? cg_rdata : (dd_rvalid ? dd_rdata : 8'h00);

    // Next-state logic
    always_comb begin
        st_d = st_q;
        if (xfer_en) begin
            if (!rd_nwr) begin
                if (!busy) begin
                    if (nibble_mode && !st_q.half) begin
                        st_d.hold = bus_in[7:4];
                        st_d.half = 1'b1;
                    end else begin
                        st_d.half = 1'b0;
                    end
                end
            end else begin
                st_d.half = nibble_mode ? !st_q.half : 1'b0;
            end
        end
        if (set_dd || set_cg) begin
            st_d.ac     = fetch_ac;
            st_d.cg_sel = fetch_cg;
            st_d.dr     = fetch_byte;
        end
        if (set_entry) st_d.inc = byte_in[1];
        if (dwr_done)  st_d.ac  = step_next;
        if (drd_done) begin
            st_d.ac = step_next;
            st_d.dr = fetch_byte;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= REGIF_RST;
        else        st_q <= st_d;
    end

    lcd_busy_timer #(.CYCLES(BUSY_CYCLES)) i_busy (
        .clk(clk), .rst_n(rst_n), .start(instr_done || dwr_done), .busy(busy)
    );

    // Read path
    always_comb begin
        view_byte = sel_data ? st_q.dr : {busy, st_q.ac};
        if (!rd_nwr)          bus_out = 8'h00;
        else if (!nibble_mode) bus_out = view_byte;
        else if (st_q.half)    bus_out = {view_byte[3:0], 4'h0};
        else                   bus_out = {view_byte[7:4], 4'h0};
    end

    assert_ignore_while_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_en && !rd_nwr && busy) |=> $stable(ac_q));

    assert_status_keeps_ac_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_en && !sel_data && rd_nwr) |=> $stable(ac_q));

    assert_glyph_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cg_sel |-> (ac_q[6] == 1'b0));

    assert_line_wrap_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (dwr_done && !st_q.cg_sel && two_line && st_q.inc && ac_q == LINE_LEN - 7'd1)
        |=> (ac_q == LINE2_BASE));

    assert_byte_mode_no_half_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_en && !nibble_mode) |=> !st_q.half);

endmodule

// File: tb/test_lcd_host_regif.sv
module test_lcd_host_regif;
    localparam int BUSY = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       xfer_en = 1'b0, sel_data = 1'b0, rd_nwr = 1'b0;
    logic       nibble_mode = 1'b0, two_line = 1'b1;
    logic [7:0] bus_in = 8'h00;
    logic [7:0] bus_out;
    logic       busy;

    int checks = 0;
    int fails  = 0;

    always #2 clk = ~clk;

    lcd_host_regif #(.BUSY_CYCLES(BUSY)) i_lcd_host_regif (
        .clk(clk), .rst_n(rst_n), .xfer_en(xfer_en), .sel_data(sel_data),
        .rd_nwr(rd_nwr), .nibble_mode(nibble_mode), .two_line(two_line),
        .bus_in(bus_in), .bus_out(bus_out), .busy(busy)
    );

    typedef struct packed {
        logic [1:0] op;   // {select, read}
        logic [7:0] din;
        logic       chk;
        logic [7:0] exp;
    } vec_t;

    localparam int NV = 14;
    localparam vec_t VECS [NV] = '{
        '{2'b00, 8'h06, 1'b0, 8'h00},  // R5 count up
        '{2'b00, 8'h80, 1'b0, 8'h00},  // R4 char addr 0
        '{2'b10, 8'h41, 1'b0, 8'h00},  // R6 write
        '{2'b10, 8'h42, 1'b0, 8'h00},
        '{2'b01, 8'h00, 1'b1, 8'h02},  // R2 status
        '{2'b00, 8'h80, 1'b0, 8'h00},  // R7 prefetch
        '{2'b11, 8'h00, 1'b1, 8'h41},  // R7 read
        '{2'b11, 8'h00, 1'b1, 8'h42},  // R7 next byte
        '{2'b01, 8'h00, 1'b1, 8'h02},  // R6 counter
        '{2'b00, 8'h40, 1'b0, 8'h00},  // R4 glyph addr 0
        '{2'b10, 8'h1F, 1'b0, 8'h00},
        '{2'b00, 8'h40, 1'b0, 8'h00},
        '{2'b11, 8'h00, 1'b1, 8'h1F},  // R1 data read
        '{2'b01, 8'h00, 1'b1, 8'h01}   // R1 status
    };

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic xfer(input logic s, input logic r, input logic [7:0] d, output logic [7:0] q);
        @(negedge clk);
        sel_data = s; rd_nwr = r; bus_in = d; xfer_en = 1'b1;
        #1 q = bus_out;
        @(negedge clk);
        xfer_en = 1'b0; rd_nwr = 1'b0;
    endtask

    task automatic wait_idle();
        while (busy) @(negedge clk);
    endtask

    task automatic wr(input logic s, input logic [7:0] d);
        logic [7:0] q;
        xfer(s, 1'b0, d, q);
        wait_idle();
    endtask

    task automatic rd(input logic s, input string tag, input logic [7:0] exp);
        logic [7:0] q;
        xfer(s, 1'b1, 8'h00, q);
        check(tag, q, exp);
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [7:0] q;
        int n;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R13 reset state
        check("R13 busy", {7'd0, busy}, 8'h00);
        rd(1'b0, "R13 status", 8'h00);
        rd(1'b1, "R13 data", 8'h00);

        // Vector table
        for (int i = 0; i < NV; i++) begin
            xfer(VECS[i].op[1], VECS[i].op[0], VECS[i].din, q);
            if (VECS[i].chk) check($sformatf("vector %0d", i), q, VECS[i].exp);
            if (!VECS[i].op[0]) wait_idle();
        end

        // R12 busy length
        wr(1'b0, 8'h80);
        xfer(1'b1, 1'b0, 8'h55, q);
        n = 0;
        while (busy) begin n++; @(negedge clk); end
        check("R12 busy length", 8'(n), 8'(BUSY));
        xfer(1'b1, 1'b1, 8'h00, q);
        check("R12 read no busy", {7'd0, busy}, 8'h00);

        // R3 writes ignored while busy
        wr(1'b0, 8'h80);
        xfer(1'b1, 1'b0, 8'h55, q);
        xfer(1'b1, 1'b0, 8'h66, q);
        wait_idle();
        rd(1'b0, "R3 data write ignored ac", 8'h01);
        xfer(1'b1, 1'b0, 8'h57, q);
        xfer(1'b0, 1'b0, 8'h90, q);
        wait_idle();
        rd(1'b0, "R3 instr ignored ac", 8'h02);
        wr(1'b0, 8'h81);
        rd(1'b1, "R3 addr1 content", 8'h57);
        wr(1'b0, 8'h80);
        rd(1'b1, "R3 addr0 content", 8'h55);

        // R9 two-line wraps
        wr(1'b0, 8'hA7);
        wr(1'b1, 8'h77);
        rd(1'b0, "R9 27h up", 8'h40);
        wr(1'b0, 8'hA7);
        rd(1'b1, "R9 readback", 8'h77);
        wr(1'b0, 8'h04);
        wr(1'b0, 8'hC0);
        wr(1'b1, 8'h11);
        rd(1'b0, "R9 40h down R5", 8'h27);
        wr(1'b0, 8'h80);
        wr(1'b1, 8'h22);
        rd(1'b0, "R9 00h down", 8'h67);
        wr(1'b0, 8'h06);
        wr(1'b0, 8'hB0);
        wr(1'b1, 8'hEE);
        wr(1'b0, 8'hB0);
        rd(1'b1, "R9 out of range", 8'h00);

        // R10 one-line wrap
        two_line = 1'b0;
        wr(1'b0, 8'hCF);
        wr(1'b1, 8'h99);
        rd(1'b0, "R10 4Fh up", 8'h00);
        wr(1'b0, 8'hCF);
        rd(1'b1, "R10 readback", 8'h99);
        two_line = 1'b1;

        // R8 glyph wrap
        wr(1'b0, 8'h7F);
        wr(1'b1, 8'h3E);
        rd(1'b0, "R8 3Fh up", 8'h00);
        wr(1'b0, 8'h7F);
        rd(1'b1, "R8 readback", 8'h3E);

        // R11 nibble mode
        nibble_mode = 1'b1;
        xfer(1'b0, 1'b0, 8'h8F, q);
        check("R11 first half no busy", {7'd0, busy}, 8'h00);
        xfer(1'b0, 1'b0, 8'h05, q);
        wait_idle();
        xfer(1'b1, 1'b0, 8'h3A, q);
        xfer(1'b1, 1'b0, 8'hC5, q);
        wait_idle();
        rd(1'b0, "R11 status high", 8'h00);
        rd(1'b0, "R11 status low", 8'h10);
        xfer(1'b0, 1'b0, 8'h8F, q);
        xfer(1'b0, 1'b0, 8'h05, q);
        wait_idle();
        rd(1'b1, "R11 data high", 8'h30);
        rd(1'b1, "R11 data low", 8'hC0);
        nibble_mode = 1'b0;

        finish_run();
    end

endmodule